// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor. Every cycle it looks at the pending, target and priority vectors that the distributor supplies. It keeps the sources that are pending, aimed at this processor, not already in service, and more urgent than the programmed priority threshold. From those it picks the most urgent one. When the interface is switched on and such a source exists, it raises the processor's interrupt request line.

Software reaches the block through a small register port with four selectable registers:
- an enable register;
- a priority threshold;
- an acknowledge register, which reports the chosen source;
- a completion register, which retires a source.

Reading the acknowledge register has a side effect. It returns the chosen ID and moves that source into service. While a source is in service it is not offered again. Writing its ID to the completion register takes it out of service. One-cycle strobes carry each acknowledge and each completion back to the distributor, so the distributor can clear or re-arm its own pending state.

Top module: `cpu_ack_if`

## Requirements
- R1: After reset, the enable bit and the priority threshold read back as 0, `irq_o` is low, and no source is in service.
- R2: A source is eligible only when all of these hold: its `pend_i` bit is 1, its `tgt_i` bit is 1, it is not in service, and its 8-bit priority field (`prio_i[8*id +: 8]`) is numerically strictly below the threshold.
- R3: Among eligible sources, the lowest priority value wins. On equal priority, the lower ID wins.
- R4: `irq_o` is a register. It is high in the cycle after one in which the enable bit was 1 and at least one source was eligible, and low otherwise.
- R5: A read of the acknowledge register (select 2) delivers `reg_rdata_o` in the next cycle. The winning ID is in bits 9:0. For IDs 0 to 15, bits 12:10 hold that ID's 3-bit field of `sgi_src_i`. For IDs 16 and above, bits 12:10 are 0.
- R6: An acknowledge read while the interface is disabled or nothing is eligible returns 1023. It raises no strobe and changes no state.
- R7: A successful acknowledge puts the ID in service and pulses `ack_vld_o` with the ID on `ack_id_o` in the next cycle. An in-service source is never offered again until it is completed.
- R8: A write to the completion register (select 3) with an in-service ID in bits 9:0 takes that ID out of service. It also pulses `eoi_vld_o` with the ID on `eoi_id_o` in the next cycle. A write naming an ID that is not in service has no effect.
- R9: Select 0 holds the enable in bit 0. Select 1 holds the 8-bit priority threshold. Both read back what was written.
- R10: A write to the acknowledge select changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 enable, 1 threshold, 2 acknowledge, 3 completion |
| reg_wdata_i | input | 10 | Write data |
| reg_rdata_o | output | 13 | Read data, registered |
| pend_i | input | NUM_IRQ | Pending flags from the distributor |
| tgt_i | input | NUM_IRQ | Flags marking sources aimed at this processor |
| prio_i | input | 8*NUM_IRQ | Priority field for each source |
| sgi_src_i | input | 48 | Originating processor number for each of IDs 0 to 15 |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_vld_o | output | 1 | Acknowledge strobe to the distributor |
| ack_id_o | output | 10 | ID that was acknowledged |
| eoi_vld_o | output | 1 | Completion strobe to the distributor |
| eoi_id_o | output | 10 | ID that was completed |

## Verification
The read data, the acknowledge strobe and the completion strobe all appear exactly one clock edge after the access that causes them. The bench drives each access on a falling edge, lets one rising edge pass, and samples on the following falling edge.

`irq_o` is registered from the enable register. A change to the pending or target inputs therefore reaches `irq_o` after one edge, and a write to the enable register after two. The bench waits three edges before it checks the line.

In-service marking and the registered `irq_o` update on the same edge. For that reason, the check that `irq_o` drops after an acknowledge is also made after a three-edge wait.

// File: rtl/ciu_pkg.sv
package ciu_pkg;
    localparam int ID_W     = 10;
    localparam int SRC_W    = 3;
    localparam int PRIO_W   = 8;
    localparam int SGI_CNT  = 16;
    localparam int RDATA_W  = ID_W + SRC_W;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_THRESH = 2'd1,
        SEL_ACK    = 2'd2,
        SEL_DONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ciu_elig.sv
// Per-source eligibility: pending, targeted, not in service, under threshold.
module ciu_elig #(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 8
) (
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [NUM_IRQ-1:0]        tgt_i,
    input  logic [NUM_IRQ-1:0]        active_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         thresh_i,
    output logic [NUM_IRQ-1:0]        elig_o
);
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
        logic under_thresh;
        assign under_thresh = prio_i[g*PRIO_W +: PRIO_W] < thresh_i;
        assign elig_o[g]    = pend_i[g] & tgt_i[g] & ~active_i[g] & under_thresh;
    end
endmodule

// File: rtl/ciu_arb.sv
// Picks the most urgent eligible source; lower ID wins on equal priority.
module ciu_arb #(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 8,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-1:0]        elig_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    output logic                      win_vld_o,
    output logic [IDX_W-1:0]          win_idx_o,
    output logic [PRIO_W-1:0]         win_prio_o
);
    always_comb begin
        win_vld_o  = 1'b0;
        win_idx_o  = '0;
        win_prio_o = '1;
        // Ascending scan with strict compare keeps the lowest ID on ties.
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig_i[i] && (!win_vld_o || prio_i[i*PRIO_W +: PRIO_W] < win_prio_o)) begin
                win_vld_o  = 1'b1;
                win_idx_o  = IDX_W'(i);
                win_prio_o = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

    p_winner_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld_o |-> elig_i[win_idx_o]);
    p_none_when_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_i == '0) |-> !win_vld_o);
endmodule

// File: rtl/ciu_state.sv
// Register file, in-service tracking and registered outputs.
module ciu_state
    import ciu_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_i,
    input  logic                     wr_i,
    input  logic [1:0]               sel_i,
    input  logic [ID_W-1:0]          wdata_i,
    input  logic                     win_vld_i,
    input  logic [IDX_W-1:0]         win_idx_i,
    input  logic                     any_elig_i,
    input  logic [SGI_CNT*SRC_W-1:0] sgi_src_i,
    output logic [RDATA_W-1:0]       rdata_o,
    output logic                     en_o,
    output logic [PRIO_W-1:0]        thresh_o,
    output logic [NUM_IRQ-1:0]       active_o,
    output logic                     irq_o,
    output logic                     ack_vld_o,
    output logic [ID_W-1:0]          ack_id_o,
    output logic                     eoi_vld_o,
    output logic [ID_W-1:0]          eoi_id_o
);
    localparam logic [ID_W-1:0] NUM_ID = ID_W'(NUM_IRQ);

    typedef struct packed {
        logic               en;
        logic [PRIO_W-1:0]  thresh;
        logic [NUM_IRQ-1:0] active;
        logic [RDATA_W-1:0] rdata;
        logic               irq;
        logic               ack_vld;
        logic [ID_W-1:0]    ack_id;
        logic               eoi_vld;
        logic [ID_W-1:0]    eoi_id;
    } state_t;

    state_t s_d, s_q;
    reg_sel_e sel;
    logic grant;
    logic [ID_W-1:0]  win_id;
    logic [SRC_W-1:0] win_src;
    logic [IDX_W-1:0] done_idx;
    logic             done_ok;

    always_comb begin
        sel      = reg_sel_e'(sel_i);
        win_id   = {{(ID_W-IDX_W){1'b0}}, win_idx_i};
        win_src  = (win_id < ID_W'(SGI_CNT)) ? sgi_src_i[win_idx_i[3:0]*SRC_W +: SRC_W] : '0;
        grant    = rd_i && (sel == SEL_ACK) && s_q.en && win_vld_i;
        done_idx = wdata_i[IDX_W-1:0];
        done_ok  = (wdata_i < NUM_ID) && s_q.active[done_idx];

        s_d         = s_q;
        s_d.ack_vld = 1'b0;
        s_d.eoi_vld = 1'b0;
        s_d.irq     = s_q.en && any_elig_i;

        if (rd_i) begin
            unique case (sel)
                SEL_ENABLE: s_d.rdata = {{(RDATA_W-1){1'b0}}, s_q.en};
                SEL_THRESH: s_d.rdata = {{(RDATA_W-PRIO_W){1'b0}}, s_q.thresh};
                SEL_ACK:    s_d.rdata = grant ? {win_src, win_id} : {{SRC_W{1'b0}}, SPURIOUS_ID};
                SEL_DONE:   s_d.rdata = '0;
            endcase
        end

        if (grant) begin
            s_d.active[win_idx_i] = 1'b1;
            s_d.ack_vld           = 1'b1;
            s_d.ack_id            = win_id;
        end

        if (wr_i) begin
            unique case (sel)
                SEL_ENABLE: s_d.en     = wdata_i[0];
                SEL_THRESH: s_d.thresh = wdata_i[PRIO_W-1:0];
                SEL_DONE: begin
                    if (done_ok) begin
                        s_d.active[done_idx] = 1'b0;
                        s_d.eoi_vld          = 1'b1;
                        s_d.eoi_id           = wdata_i;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata_o   = s_q.rdata;
    assign en_o      = s_q.en;
    assign thresh_o  = s_q.thresh;
    assign active_o  = s_q.active;
    assign irq_o     = s_q.irq;
    assign ack_vld_o = s_q.ack_vld;
    assign ack_id_o  = s_q.ack_id;
    assign eoi_vld_o = s_q.eoi_vld;
    assign eoi_id_o  = s_q.eoi_id;

    p_irq_off_when_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(s_q.en) |-> !irq_o);
    p_ack_not_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld_o |-> (ack_id_o < NUM_ID));
    p_ack_marks_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld_o |-> s_q.active[ack_id_o[IDX_W-1:0]]);
    p_eoi_clears_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_vld_o && !ack_vld_o) |-> !s_q.active[eoi_id_o[IDX_W-1:0]]);
    p_ack_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld_o |-> $past(s_q.en));
endmodule

// File: rtl/cpu_ack_if.sv
module cpu_ack_if
    import ciu_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_rd_i,
    input  logic                      reg_wr_i,
    input  logic [1:0]                reg_sel_i,
    input  logic [ID_W-1:0]           reg_wdata_i,
    output logic [RDATA_W-1:0]        reg_rdata_o,
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [NUM_IRQ-1:0]        tgt_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    input  logic [SGI_CNT*SRC_W-1:0]  sgi_src_i,
    output logic                      irq_o,
    output logic                      ack_vld_o,
    output logic [ID_W-1:0]           ack_id_o,
    output logic                      eoi_vld_o,
    output logic [ID_W-1:0]           eoi_id_o
);
    logic [NUM_IRQ-1:0] elig;
    logic [NUM_IRQ-1:0] active;
    logic [PRIO_W-1:0]  thresh;
    logic               en;
    logic               win_vld;
    logic [IDX_W-1:0]   win_idx;
    logic [PRIO_W-1:0]  win_prio;

    ciu_elig #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) i_elig (
        .pend_i  (pend_i),
        .tgt_i   (tgt_i),
        .active_i(active),
        .prio_i  (prio_i),
        .thresh_i(thresh),
        .elig_o  (elig)
    );

    ciu_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig_i    (elig),
        .prio_i    (prio_i),
        .win_vld_o (win_vld),
        .win_idx_o (win_idx),
        .win_prio_o(win_prio)
    );

    ciu_state #(.NUM_IRQ(NUM_IRQ)) i_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_i      (reg_rd_i),
        .wr_i      (reg_wr_i),
        .sel_i     (reg_sel_i),
        .wdata_i   (reg_wdata_i),
        .win_vld_i (win_vld),
        .win_idx_i (win_idx),
        .any_elig_i(win_vld),
        .sgi_src_i (sgi_src_i),
        .rdata_o   (reg_rdata_o),
        .en_o      (en),
        .thresh_o  (thresh),
        .active_o  (active),
        .irq_o     (irq_o),
        .ack_vld_o (ack_vld_o),
        .ack_id_o  (ack_id_o),
        .eoi_vld_o (eoi_vld_o),
        .eoi_id_o  (eoi_id_o)
    );

    p_win_below_thresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> (win_prio < thresh));
    p_win_pending_targeted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> (pend_i[win_idx] && tgt_i[win_idx] && !active[win_idx]));
    p_irq_follows_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $past(win_vld)) |-> irq_o);
endmodule

// File: tb/test_cpu_ack_if.sv
module test_cpu_ack_if;
    import ciu_pkg::*;
    localparam int N = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd = 1'b0, wr = 1'b0;
    logic [1:0] sel = '0;
    logic [ID_W-1:0] wdata = '0;
    logic [RDATA_W-1:0] rdata;
    logic [N-1:0] pend = '0, tgt = '1;
    logic [N*PRIO_W-1:0] prio = '1;
    logic [SGI_CNT*SRC_W-1:0] sgi_src = '0;
    logic irq, ack_vld, eoi_vld;
    logic [ID_W-1:0] ack_id, eoi_id;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cpu_ack_if #(.NUM_IRQ(N)) i_cpu_ack_if (
        .clk(clk), .rst_n(rst_n), .reg_rd_i(rd), .reg_wr_i(wr), .reg_sel_i(sel),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pend_i(pend), .tgt_i(tgt),
        .prio_i(prio), .sgi_src_i(sgi_src), .irq_o(irq), .ack_vld_o(ack_vld),
        .ack_id_o(ack_id), .eoi_vld_o(eoi_vld), .eoi_id_o(eoi_id)
    );

    typedef struct packed {
        logic [9:0]  a;
        logic [7:0]  pa;
        logic [9:0]  b;
        logic [7:0]  pb;
        logic [7:0]  mask;
        logic [12:0] exp;
    } vec_t;

    // Expected values follow R2, R3 and R5; sgi_src for ID 5 is 3.
    localparam vec_t VECS [8] = '{
        '{10'd40, 8'hA0, 10'd33, 8'hA0, 8'hF0, 13'd33},   // tie -> lower ID
        '{10'd40, 8'h20, 10'd33, 8'hA0, 8'hF0, 13'd40},   // lower prio value wins
        '{10'd5,  8'h80, 10'd20, 8'h90, 8'hF0, 13'h0C05}, // source field
        '{10'd50, 8'hF0, 10'd51, 8'hF5, 8'hF0, 13'd1023}, // equal to threshold blocked
        '{10'd50, 8'hEF, 10'd51, 8'hF0, 8'hF0, 13'd50},
        '{10'd63, 8'h00, 10'd0,  8'h00, 8'hF0, 13'd0},
        '{10'd10, 8'h00, 10'd10, 8'h00, 8'h00, 13'd1023}, // threshold 0 blocks all
        '{10'd17, 8'h40, 10'd18, 8'h3F, 8'hF0, 13'd18}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] s, input logic [ID_W-1:0] d);
        @(negedge clk);
        wr = 1'b1; sel = s; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] s);
        @(negedge clk);
        rd = 1'b1; sel = s;
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        sgi_src[5*SRC_W +: SRC_W] = 3'd3;
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", irq, 0);
        reg_read(SEL_ENABLE);  chk("R1 enable", rdata, 0);
        reg_read(SEL_THRESH);  chk("R1 thresh", rdata, 0);
        reg_read(SEL_ACK);     chk("R6 empty ack", rdata, 1023);

        // Vector table: R2 R3 R4 R5 R7 R8
        for (int v = 0; v < 8; v++) begin
            int a, b;
            bit hit;
            a = int'(VECS[v].a);
            b = int'(VECS[v].b);
            hit = (VECS[v].exp[9:0] != 10'd1023);
            prio = '1; pend = '0; tgt = '1;
            prio[a*8 +: 8] = VECS[v].pa;
            prio[b*8 +: 8] = VECS[v].pb;
            pend[a] = 1'b1; pend[b] = 1'b1;
            reg_write(SEL_THRESH, {2'b0, VECS[v].mask});
            reg_write(SEL_ENABLE, 10'd1);
            wait_cyc(3);
            chk($sformatf("R4 irq vec%0d", v), irq, hit);
            reg_read(SEL_ACK);
            chk($sformatf("R3 R5 ack vec%0d", v), rdata, VECS[v].exp);
            chk($sformatf("R7 ack strobe vec%0d", v), ack_vld, hit);
            if (hit) begin
                chk($sformatf("R7 ack id vec%0d", v), ack_id, VECS[v].exp[9:0]);
                pend[VECS[v].exp[5:0]] = 1'b0;
                reg_write(SEL_DONE, VECS[v].exp[9:0]);
                chk($sformatf("R8 eoi strobe vec%0d", v), eoi_vld, 1);
                chk($sformatf("R8 eoi id vec%0d", v), eoi_id, VECS[v].exp[9:0]);
            end
            pend = '0;
        end

        // R9: threshold readback
        reg_write(SEL_THRESH, 10'h3F5);
        reg_read(SEL_THRESH);  chk("R9 thresh readback", rdata, 13'hF5);
        reg_write(SEL_THRESH, 10'h0F0);

        // R4/R6: disabled interface
        reg_write(SEL_ENABLE, 10'd0);
        reg_read(SEL_ENABLE);  chk("R9 enable readback", rdata, 0);
        prio = '1; prio[40*8 +: 8] = 8'h10; pend[40] = 1'b1;
        wait_cyc(3);
        chk("R4 irq disabled", irq, 0);
        reg_read(SEL_ACK);
        chk("R6 ack disabled", rdata, 1023);
        chk("R6 no strobe", ack_vld, 0);

        // R2: untargeted source
        reg_write(SEL_ENABLE, 10'd1);
        tgt[40] = 1'b0;
        wait_cyc(3);
        chk("R2 untargeted irq", irq, 0);
        reg_read(SEL_ACK);     chk("R2 untargeted ack", rdata, 1023);
        tgt[40] = 1'b1;

        // R7/R8: in-service source held off until completion
        reg_read(SEL_ACK);     chk("R7 first ack", rdata, 40);
        wait_cyc(3);
        chk("R7 irq drops", irq, 0);
        reg_read(SEL_ACK);     chk("R7 not reoffered", rdata, 1023);
        reg_write(SEL_DONE, 10'd41);
        chk("R8 stray eoi no strobe", eoi_vld, 0);
        reg_read(SEL_ACK);     chk("R8 stray eoi no effect", rdata, 1023);
        reg_write(SEL_DONE, 10'd40);
        chk("R8 eoi strobe", eoi_vld, 1);
        chk("R8 eoi id", eoi_id, 40);
        reg_read(SEL_ACK);     chk("R8 reoffered", rdata, 40);

        // R10: write to acknowledge select changes nothing
        reg_write(SEL_ACK, 10'h3FF);
        reg_read(SEL_ENABLE);  chk("R10 enable kept", rdata, 1);
        reg_read(SEL_THRESH);  chk("R10 thresh kept", rdata, 13'hF0);

        // R1: reset clears in-service state
        do_reset();
        reg_write(SEL_THRESH, 10'h0F0);
        reg_write(SEL_ENABLE, 10'd1);
        reg_read(SEL_ACK);     chk("R1 in-service cleared", rdata, 40);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule